// File: doc/BRIEF.md
# Transfer Count and Activation-Enable Unit

This block keeps track of how many data transfers remain for one channel of a small, interrupt-triggered transfer engine. It also holds that channel's activation-enable bit. Software or the engine loads two count registers. The engine then pulses a strobe once per moved data unit. The unit counts down, reports a reload event when a repeat or block window wraps, and reports a transfer-end event when the programmed work is finished.

Three modes are supported. In normal mode, count A is one wide down-counter. In repeat and block modes, count A is split into two halves: the upper half is a reload value and the lower half is a live counter. Block mode also uses count B to count completed blocks. The enable bit clears itself when the work finishes, or on every transfer when the disable-interrupt select is set. Software can clear it only with a read-then-write-zero sequence.

Top module: `xfer_count_unit`

## Requirements
- R1: After reset, cntA and cntB are 0, and xferEnd, reload and enable are 0.
- R2: In mode 0 (normal) or mode 3 (treated as normal), each xferStb without loadA decrements the whole of cntA by 1. xferEnd pulses for one cycle, together with the new count, when cntA was 1 at the strobe. A strobe with cntA at 0 wraps it to all ones and does not signal an end.
- R3: In mode 1 (repeat) and mode 2 (block), the strobe decrements only the low half of cntA (bits 7:0 at the default width). When the low half is 1 at the strobe, the low half takes the value of the high half and reload pulses for one cycle. A low half of 0 wraps to all ones, which gives 256 transfers.
- R4: In mode 1, xferEnd is never asserted.
- R5: In mode 2, cntB decrements by 1 on each reload event, and xferEnd pulses when cntB was 1 at that event.
- R6: In modes 0, 1 and 3, cntB changes only through loadB.
- R7: loadA and loadB have priority over the count updates on the same cycle. The loaded value appears one cycle later.
- R8: enLoad writes enLoadVal into enable with top priority. A busWr with busWrData=1 sets enable.
- R9: enable clears on the same edge on which xferEnd is raised, unless enLoad is active.
- R10: When dieSel is 1, every xferStb clears enable, unless enLoad is active.
- R11: When dieSel is 0 and no end occurs, a transfer leaves enable unchanged.
- R12: A busWr with busWrData=0 clears enable only if a busRd saw enable=1 since the last write, load or automatic clear. Otherwise enable stays as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 0 normal, 1 repeat, 2 block, 3 normal |
| loadA | input | 1 | Load count A |
| loadAVal | input | CNT_W | Value for count A |
| loadB | input | 1 | Load count B |
| loadBVal | input | CNT_W | Value for count B |
| xferStb | input | 1 | One data transfer done |
| dieSel | input | 1 | Clear enable after every transfer |
| enLoad | input | 1 | Load the enable bit |
| enLoadVal | input | 1 | Value for the enable bit |
| busRd | input | 1 | Bus read of the enable bit |
| busWr | input | 1 | Bus write of the enable bit |
| busWrData | input | 1 | Bus write data |
| cntA | output | CNT_W | Current count A |
| cntB | output | CNT_W | Current count B |
| xferEnd | output | 1 | One-cycle transfer-end pulse |
| reload | output | 1 | One-cycle low-half reload pulse |
| enable | output | 1 | Activation-enable state |

## Verification
The bench builds the unit with the default CNT_W of 16, so the counter halves are 8 bits wide. Random loads favour small counter values and zeros. This brings the wide wrap from 0, the 256-count low-half wrap and block-count exhaustion within a few thousand cycles. Bus reads and writes are mixed with dieSel toggling, so that every priority in the read-then-clear sequence meets an automatic clear.

// File: rtl/xcu_pkg.sv
package xcu_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_REPEAT = 2'd1,
    MODE_BLOCK  = 2'd2,
    MODE_ALT    = 2'd3
  } xcuMode_e;

  typedef struct packed {
    logic ldA;
    logic ldB;
    logic decWide;
    logic decLo;
    logic reloadLo;
    logic decB;
  } dpStrobes_t;
endpackage

// File: rtl/xcu_datapath.sv
module xcu_datapath
  import xcu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       stb,
  input  logic [CNT_W-1:0] loadAVal,
  input  logic [CNT_W-1:0] loadBVal,
  output logic [CNT_W-1:0] cntA,
  output logic [CNT_W-1:0] cntB
);
  localparam int HALF = CNT_W / 2;

  logic [HALF-1:0] hiHalf;
  logic [HALF-1:0] loHalf;

  assign hiHalf = cntA[CNT_W-1:HALF];
  assign loHalf = cntA[HALF-1:0];

  // Count A: load, wide decrement, low-half reload or low-half decrement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntA <= '0;
    end else if (stb.ldA) begin
      cntA <= loadAVal;
    end else if (stb.decWide) begin
      cntA <= cntA - CNT_W'(1);
    end else if (stb.reloadLo) begin
      cntA[HALF-1:0] <= hiHalf;
    end else if (stb.decLo) begin
      cntA[HALF-1:0] <= loHalf - HALF'(1);
    end
  end

  // Count B: block counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntB <= '0;
    end else if (stb.ldB) begin
      cntB <= loadBVal;
    end else if (stb.decB) begin
      cntB <= cntB - CNT_W'(1);
    end
  end
endmodule

// File: rtl/xcu_ctrl.sv
module xcu_ctrl
  import xcu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             loadA,
  input  logic             loadB,
  input  logic             xferStb,
  input  logic             dieSel,
  input  logic             enLoad,
  input  logic             enLoadVal,
  input  logic             busRd,
  input  logic             busWr,
  input  logic             busWrData,
  input  logic [CNT_W-1:0] cntA,
  input  logic [CNT_W-1:0] cntB,
  output dpStrobes_t       stb,
  output logic             xferEnd,
  output logic             reload,
  output logic             enable
);
  localparam int HALF = CNT_W / 2;

  xcuMode_e modeE;
  logic     isSplit;
  logic     isBlock;
  logic     lastLo;
  logic     stepA;
  logic     endNow;
  logic     autoClr;
  logic     armed;

  assign modeE   = xcuMode_e'(mode);
  assign isSplit = (modeE == MODE_REPEAT) || (modeE == MODE_BLOCK);
  assign isBlock = (modeE == MODE_BLOCK);
  assign lastLo  = (cntA[HALF-1:0] == HALF'(1));
  assign stepA   = xferStb && !loadA;

  always_comb begin
    stb          = '0;
    stb.ldA      = loadA;
    stb.ldB      = loadB;
    stb.decWide  = stepA && !isSplit;
    stb.reloadLo = stepA && isSplit && lastLo;
    stb.decLo    = stepA && isSplit && !lastLo;
    stb.decB     = stb.reloadLo && isBlock && !loadB;
  end

  assign endNow  = (stb.decWide && (cntA == CNT_W'(1))) ||
                   (stb.decB && (cntB == CNT_W'(1)));
  assign autoClr = endNow || (dieSel && xferStb);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferEnd <= 1'b0;
      reload  <= 1'b0;
    end else begin
      xferEnd <= endNow;
      reload  <= stb.reloadLo;
    end
  end

  // Enable bit: load port, then automatic clear, then bus write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (enLoad) begin
        enable <= enLoadVal;
      end else if (autoClr) begin
        enable <= 1'b0;
      end else if (busWr) begin
        if (busWrData) begin
          enable <= 1'b1;
        end else if (armed) begin
          enable <= 1'b0;
        end
      end

      if (enLoad || autoClr || busWr) begin
        armed <= 1'b0;
      end else if (busRd && enable) begin
        armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/xfer_count_unit.sv
module xfer_count_unit
  import xcu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             loadA,
  input  logic [CNT_W-1:0] loadAVal,
  input  logic             loadB,
  input  logic [CNT_W-1:0] loadBVal,
  input  logic             xferStb,
  input  logic             dieSel,
  input  logic             enLoad,
  input  logic             enLoadVal,
  input  logic             busRd,
  input  logic             busWr,
  input  logic             busWrData,
  output logic [CNT_W-1:0] cntA,
  output logic [CNT_W-1:0] cntB,
  output logic             xferEnd,
  output logic             reload,
  output logic             enable
);
  dpStrobes_t stb;

  xcu_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .mode     (mode),
    .loadA    (loadA),
    .loadB    (loadB),
    .xferStb  (xferStb),
    .dieSel   (dieSel),
    .enLoad   (enLoad),
    .enLoadVal(enLoadVal),
    .busRd    (busRd),
    .busWr    (busWr),
    .busWrData(busWrData),
    .cntA     (cntA),
    .cntB     (cntB),
    .stb      (stb),
    .xferEnd  (xferEnd),
    .reload   (reload),
    .enable   (enable)
  );

  xcu_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .loadAVal(loadAVal),
    .loadBVal(loadBVal),
    .cntA    (cntA),
    .cntB    (cntB)
  );
endmodule

// File: rtl/xcu_checker.sv
module xcu_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       mode,
  input logic             loadA,
  input logic             loadB,
  input logic             xferStb,
  input logic             dieSel,
  input logic             enLoad,
  input logic [CNT_W-1:0] cntA,
  input logic [CNT_W-1:0] cntB,
  input logic             xferEnd,
  input logic             reload,
  input logic             enable
);
  localparam int HALF = CNT_W / 2;

  p_wide_dec_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == 2'd0 || mode == 2'd3) && xferStb && !loadA)
      |=> (cntA == $past(cntA) - CNT_W'(1)));

  p_lo_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == 2'd1 || mode == 2'd2) && xferStb && !loadA && cntA[HALF-1:0] == HALF'(1))
      |=> (reload && cntA[HALF-1:0] == $past(cntA[CNT_W-1:HALF])));

  p_repeat_no_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1) |=> !xferEnd);

  p_b_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'd2 && !loadB) |=> $stable(cntB));

  p_a_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!xferStb && !loadA) |=> $stable(cntA));

  p_end_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(xferEnd) && !$past(enLoad)) |-> !enable);

  p_die_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dieSel && xferStb && !enLoad) |=> !enable);

  p_no_reload_plain_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!xferStb || loadA) |=> !reload);
endmodule

bind xfer_count_unit xcu_checker #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .mode   (mode),
  .loadA  (loadA),
  .loadB  (loadB),
  .xferStb(xferStb),
  .dieSel (dieSel),
  .enLoad (enLoad),
  .cntA   (cntA),
  .cntB   (cntB),
  .xferEnd(xferEnd),
  .reload (reload),
  .enable (enable)
);

// File: tb/tb_xfer_count_unit.sv
module tb_xfer_count_unit;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   mode = '0;
  logic         loadA = 0, loadB = 0, xferStb = 0, dieSel = 0;
  logic         enLoad = 0, enLoadVal = 0, busRd = 0, busWr = 0, busWrData = 0;
  logic [W-1:0] loadAVal = '0, loadBVal = '0;
  logic [W-1:0] cntA, cntB;
  logic         xferEnd, reload, enable;

  int nChk = 0;
  int nBad = 0;

  // Reference state
  logic [W-1:0] mA = '0, mB = '0;
  logic         mEnd = 0, mRel = 0, mEn = 0, mArm = 0;

  always #2.5 clk = ~clk;

  xfer_count_unit #(.CNT_W(W)) dut (
    .clk(clk), .rstN(rstN), .mode(mode),
    .loadA(loadA), .loadAVal(loadAVal), .loadB(loadB), .loadBVal(loadBVal),
    .xferStb(xferStb), .dieSel(dieSel), .enLoad(enLoad), .enLoadVal(enLoadVal),
    .busRd(busRd), .busWr(busWr), .busWrData(busWrData),
    .cntA(cntA), .cntB(cntB), .xferEnd(xferEnd), .reload(reload), .enable(enable)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic splitMode(input logic [1:0] m);
    return (m == 2'd1) || (m == 2'd2);
  endfunction

  // Advance the model by one clock, given the present inputs
  task automatic modelStep();
    logic [W-1:0] nA, nB;
    logic nEnd, nRel, nEn, nArm, clr;
    nA = mA; nB = mB; nEnd = 0; nRel = 0; nEn = mEn; nArm = mArm;
    if (loadA) nA = loadAVal;
    else if (xferStb) begin
      if (!splitMode(mode)) begin
        nA = mA - 1'b1;
        nEnd = (mA == 16'd1);
      end else if (mA[7:0] == 8'd1) begin
        nA[7:0] = mA[15:8];
        nRel = 1;
        if (mode == 2'd2 && !loadB) begin
          nB = mB - 1'b1;
          nEnd = (mB == 16'd1);
        end
      end else begin
        nA[7:0] = mA[7:0] - 8'd1;
      end
    end
    if (loadB) nB = loadBVal;
    clr = nEnd || (dieSel && xferStb);
    if (enLoad) nEn = enLoadVal;
    else if (clr) nEn = 0;
    else if (busWr) nEn = busWrData ? 1'b1 : (mArm ? 1'b0 : mEn);
    if (enLoad || clr || busWr) nArm = 0;
    else if (busRd && mEn) nArm = 1;
    mA = nA; mB = nB; mEnd = nEnd; mRel = nRel; mEn = nEn; mArm = nArm;
  endtask

  task automatic cyc();
    modelStep();
    @(posedge clk);
    #1;
    chk("R2 R3 R7 cntA", cntA, mA);
    chk("R5 R6 R7 cntB", cntB, mB);
    chk("R2 R4 R5 xferEnd", W'(xferEnd), W'(mEnd));
    chk("R3 reload", W'(reload), W'(mRel));
    chk("R8 R9 R10 R11 R12 enable", W'(enable), W'(mEn));
    loadA = 0; loadB = 0; xferStb = 0; enLoad = 0; busRd = 0; busWr = 0;
  endtask

  initial begin : watchdog
    #(5 * 150000);
    nBad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    #12;
    chk("R1 cntA", cntA, '0);
    chk("R1 cntB", cntB, '0);
    chk("R1 flags", W'({xferEnd, reload, enable}), '0);
    @(negedge clk);
    rstN = 1;
    @(posedge clk); #1;

    // R2: normal count of 2, end on second strobe
    mode = 0; loadA = 1; loadAVal = 16'd2; enLoad = 1; enLoadVal = 1; cyc();
    xferStb = 1; cyc();
    chk("R11 enable kept", W'(enable), 16'd1);
    xferStb = 1; cyc();
    chk("R2 end pulse", W'(xferEnd), 16'd1);
    chk("R9 enable cleared", W'(enable), 16'd0);
    cyc();
    chk("R2 pulse one cycle", W'(xferEnd), 16'd0);
    // R2: zero means 65536
    loadA = 1; loadAVal = 16'd0; cyc();
    xferStb = 1; cyc();
    chk("R2 wrap no end", {cntA[15:1], xferEnd}, 16'hFFFE);

    // R3/R4: repeat, hi=3 lo=1
    mode = 1; loadA = 1; loadAVal = 16'h0301; cyc();
    xferStb = 1; cyc();
    chk("R3 reload value", cntA, 16'h0303);
    chk("R4 no end", W'(xferEnd), 16'd0);

    // R5: block, two blocks of two
    mode = 2; loadA = 1; loadAVal = 16'h0202; loadB = 1; loadBVal = 16'd2;
    enLoad = 1; enLoadVal = 1; cyc();
    for (int i = 0; i < 4; i++) begin xferStb = 1; cyc(); end
    chk("R5 block end", W'(xferEnd), 16'd1);
    chk("R5 cntB zero", cntB, 16'd0);

    // R12: zero write without read ignored, after read clears
    enLoad = 1; enLoadVal = 1; cyc();
    busWr = 1; busWrData = 0; cyc();
    chk("R12 unread zero ignored", W'(enable), 16'd1);
    busRd = 1; cyc();
    busWr = 1; busWrData = 0; cyc();
    chk("R12 read then zero clears", W'(enable), 16'd0);
    busWr = 1; busWrData = 1; cyc();
    chk("R8 write one sets", W'(enable), 16'd1);
    // R10
    mode = 1; dieSel = 1; xferStb = 1; cyc();
    chk("R10 dieSel clears", W'(enable), 16'd0);
    dieSel = 0;

    // Random phase
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) mode = 2'($urandom_range(0, 3));
      xferStb = ($urandom_range(0, 99) < 60);
      if ($urandom_range(0, 99) < 4) begin
        loadA = 1;
        loadAVal = {8'($urandom_range(0, 3)), 8'($urandom_range(0, 3))};
      end
      if ($urandom_range(0, 99) < 3) begin
        loadB = 1; loadBVal = 16'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 99) < 5) dieSel = ~dieSel;
      if ($urandom_range(0, 99) < 4) begin enLoad = 1; enLoadVal = 1'($urandom); end
      busRd = ($urandom_range(0, 99) < 10);
      if ($urandom_range(0, 99) < 8) begin busWr = 1; busWrData = 1'($urandom); end
      cyc();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule